// File: doc/BRIEF.md
# Indexed Host Port Packet Buffer

This block sits between a 16-bit host bus and the word-organised packet SRAM of a small Ethernet controller. The host reaches every register through two addresses: an index port that selects a register number and a data port through which the selected register is read or written. Three data-port commands move frame data. One streams words into the transmit region. One streams words out of the receive region. A third peeks at the next receive word without consuming it, so the host can inspect a frame header before it drains the frame.

The receive side offers a plain writer port. An external MAC stores each frame at the receive write pointer: first a header word carrying a ready mark of 0x01 in its low byte and the receive status in bits [15:8], then the frame length including the 4-byte FCS, then the data. The MAC then commits the frame. On the transmit side, a request level and a completion pulse stand in for the transmit engine. That engine fetches the frame words through a separate read port. The buffer depth is a parameter. When the split bit is set, three sixteenths of the buffer go to transmit and the rest to receive.

Top module: `pktbuf_host_port`

## Requirements
- R1: A host write with `host_sel_i`=0 loads the register index from `host_wdata_i[7:0]`. A read with `host_sel_i`=0 returns that index. Accesses with `host_sel_i`=1 reach the selected register. Every read returns its data on `host_rdata_o` with `host_rvalid_o` high in the cycle after the read strobe.
- R2: A data write with index 0xF8 stores the 16-bit word at the transmit write pointer and then advances that pointer by one word. After reset the pointer starts at word 0.
- R3: A data read with index 0xF2 returns the word at the receive read pointer and advances the pointer. A read with index 0xF0 returns the same word without advancing.
- R4: With bit 7 of register 0xFF set, words [0, TX_WORDS) form the transmit region and words [TX_WORDS, BUF_WORDS) form the receive region, where TX_WORDS = BUF_WORDS*3/16. Each pointer wraps to the base of its own region. With the bit clear, every pointer spans the whole buffer from word 0. A write that changes the bit moves all pointers to the new bases.
- R5: Index 0xFC holds the low byte and index 0xFD the high byte of the transmit length. Both read back and drive `tx_len_o`.
- R6: Writing 1 to bit 0 of register 0x02 raises `tx_req_o`. The bit reads back as 1 until a `tx_done_i` pulse arrives while the request is pending, and then clears.
- R7: A completed transmission sets bit 1 of register 0xFE and returns the transmit write pointer to word 0.
- R8: `rx_wr_i` stores `rx_wdata_i` at the receive write pointer and advances that pointer. Stored words become visible to host reads only after a later `rx_commit_i` pulse, which also sets bit 0 of register 0xFE.
- R9: Writing 1 to a bit of register 0xFE clears that bit. Writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: When the receive read pointer equals the committed write pointer, reads with index 0xF0 and 0xF2 return 0x0000 and the pointer does not move.
- R11: Writing 1 to bit 0 of register 0x00 starts a soft reset. For RST_CYCLES cycles the bit reads 1, host data writes are ignored, and the pointers, events, transmit request, length and register 0xFF return to their reset values. The bit then reads 0.
- R12: After `rst_ni` is released, all registers read 0, `tx_req_o` is low and `tx_len_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_cs_i | input | 1 | Host access strobe |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_sel_i | input | 1 | 0 = index port, 1 = data port |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data |
| host_rvalid_o | output | 1 | Read data valid |
| tx_req_o | output | 1 | Transmit request pending |
| tx_len_o | output | 16 | Transmit frame length |
| tx_done_i | input | 1 | Transmit completion pulse |
| mac_rd_addr_i | input | AW | Word address for the MAC fetch port |
| mac_rd_data_o | output | 16 | Fetched word, one cycle after the address |
| rx_wr_i | input | 1 | Receive word write strobe |
| rx_wdata_i | input | 16 | Receive word |
| rx_commit_i | input | 1 | Frame commit pulse |

## Verification
Transmit streaming is tried with a short burst and with a burst long enough to pass the transmit region end. The short burst shows that words land at consecutive addresses. The long burst tells wrapping to the region base apart from running into the receive region. Receive streaming is tried with a header-plus-data frame, with peeks mixed among consuming reads, and with a region-filling frame. These separate the advancing read from the non-advancing one, show that uncommitted words stay hidden, and expose a wrong wrap base. Reads from an empty buffer, a soft reset in the middle of activity, and completion events with write-one-to-clear show whether state changes only through the documented paths.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;
  localparam logic [7:0] IX_NET_CTRL = 8'h00;
  localparam logic [7:0] IX_TX_CTRL  = 8'h02;
  localparam logic [7:0] IX_RD_PEEK  = 8'hF0;
  localparam logic [7:0] IX_RD_INC   = 8'hF2;
  localparam logic [7:0] IX_WR_INC   = 8'hF8;
  localparam logic [7:0] IX_LEN_LO   = 8'hFC;
  localparam logic [7:0] IX_LEN_HI   = 8'hFD;
  localparam logic [7:0] IX_EVT      = 8'hFE;
  localparam logic [7:0] IX_CFG      = 8'hFF;
  localparam int         CFG_SPLIT   = 7;
endpackage

// File: rtl/pktbuf_ring_ptr.sv
module pktbuf_ring_ptr #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [AW-1:0] clr_base_i,
  input  logic [AW-1:0] wrap_base_i,
  input  logic [AW-1:0] last_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (clr_i)  ptr_o <= clr_base_i;
    else if (inc_i)  ptr_o <= (ptr_o == last_i) ? wrap_base_i : ptr_o + 1'b1;
  end
endmodule

// File: rtl/pktbuf_sram.sv
module pktbuf_sram #(
  parameter int WORDS = 2048,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          wa_en_i,
  input  logic [AW-1:0] wa_addr_i,
  input  logic [15:0]   wa_data_i,
  input  logic          wb_en_i,
  input  logic [AW-1:0] wb_addr_i,
  input  logic [15:0]   wb_data_i,
  input  logic [AW-1:0] ra_addr_i,
  output logic [15:0]   ra_data_o,
  input  logic [AW-1:0] rb_addr_i,
  output logic [15:0]   rb_data_o
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk_i) begin
    if (wa_en_i) mem[wa_addr_i] <= wa_data_i;
    if (wb_en_i) mem[wb_addr_i] <= wb_data_i;
    ra_data_o <= mem[ra_addr_i];
    rb_data_o <= mem[rb_addr_i];
  end
endmodule

// File: rtl/pktbuf_host_port.sv
module pktbuf_host_port
  import pktbuf_pkg::*;
#(
  parameter int  BUF_WORDS  = 2048,
  parameter int  RST_CYCLES = 8,
  localparam int AW         = $clog2(BUF_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_cs_i,
  input  logic          host_we_i,
  input  logic          host_sel_i,
  input  logic [15:0]   host_wdata_i,
  output logic [15:0]   host_rdata_o,
  output logic          host_rvalid_o,
  output logic          tx_req_o,
  output logic [15:0]   tx_len_o,
  input  logic          tx_done_i,
  input  logic [AW-1:0] mac_rd_addr_i,
  output logic [15:0]   mac_rd_data_o,
  input  logic          rx_wr_i,
  input  logic [15:0]   rx_wdata_i,
  input  logic          rx_commit_i
);
  localparam int TX_WORDS = BUF_WORDS * 3 / 16;
  localparam int CW       = $clog2(RST_CYCLES + 1);

  logic [7:0]    idx_q, cfg_q;
  logic [15:0]   len_q, rd_reg_q, reg_val, sram_q;
  logic [1:0]    isr_q, isr_set, isr_clr;
  logic [CW-1:0] srst_cnt;
  logic          tx_req_q, rvalid_q, from_mem_q;
  logic [AW-1:0] tx_wp, rx_wp, rx_rp, rx_cp;

  wire host_rd  = host_cs_i & ~host_we_i;
  wire host_wr  = host_cs_i & host_we_i;
  wire srst_busy = (srst_cnt != '0);
  wire dwr      = host_wr & host_sel_i & ~srst_busy;
  wire drd      = host_rd & host_sel_i;
  wire rx_empty = (rx_rp == rx_cp);
  wire is_rd_cmd = (idx_q == IX_RD_PEEK) | (idx_q == IX_RD_INC);
  wire tx_fin   = tx_req_q & tx_done_i & ~srst_busy;
  wire cfg_wr   = dwr & (idx_q == IX_CFG);

  wire part_q   = cfg_q[CFG_SPLIT];
  wire part_nxt = srst_busy ? 1'b0 : (cfg_wr ? host_wdata_i[CFG_SPLIT] : part_q);
  wire clr_all  = srst_busy | (part_nxt != part_q);

  wire [AW-1:0] tx_last  = part_q ? AW'(TX_WORDS - 1) : AW'(BUF_WORDS - 1);
  wire [AW-1:0] rx_base  = part_q ? AW'(TX_WORDS) : '0;
  wire [AW-1:0] rx_cbase = part_nxt ? AW'(TX_WORDS) : '0;
  wire [AW-1:0] buf_last = AW'(BUF_WORDS - 1);

  wire tx_inc = dwr & (idx_q == IX_WR_INC);
  wire rx_inc = rx_wr_i & ~srst_busy;
  wire rd_inc = drd & (idx_q == IX_RD_INC) & ~rx_empty & ~srst_busy;

  pktbuf_ring_ptr #(.AW(AW)) u_tx_wp (
    .clk_i, .rst_ni, .clr_i(clr_all | tx_fin), .clr_base_i('0), .wrap_base_i('0),
    .last_i(tx_last), .inc_i(tx_inc), .ptr_o(tx_wp));

  pktbuf_ring_ptr #(.AW(AW)) u_rx_wp (
    .clk_i, .rst_ni, .clr_i(clr_all), .clr_base_i(rx_cbase), .wrap_base_i(rx_base),
    .last_i(buf_last), .inc_i(rx_inc), .ptr_o(rx_wp));

  pktbuf_ring_ptr #(.AW(AW)) u_rx_rp (
    .clk_i, .rst_ni, .clr_i(clr_all), .clr_base_i(rx_cbase), .wrap_base_i(rx_base),
    .last_i(buf_last), .inc_i(rd_inc), .ptr_o(rx_rp));

  pktbuf_sram #(.WORDS(BUF_WORDS)) u_sram (
    .clk_i,
    .wa_en_i(tx_inc),  .wa_addr_i(tx_wp), .wa_data_i(host_wdata_i),
    .wb_en_i(rx_inc),  .wb_addr_i(rx_wp), .wb_data_i(rx_wdata_i),
    .ra_addr_i(rx_rp), .ra_data_o(sram_q),
    .rb_addr_i(mac_rd_addr_i), .rb_data_o(mac_rd_data_o));

  always_comb begin
    unique case (idx_q)
      IX_NET_CTRL: reg_val = {15'b0, srst_busy};
      IX_TX_CTRL:  reg_val = {15'b0, tx_req_q};
      IX_LEN_LO:   reg_val = {8'b0, len_q[7:0]};
      IX_LEN_HI:   reg_val = {8'b0, len_q[15:8]};
      IX_EVT:      reg_val = {14'b0, isr_q};
      IX_CFG:      reg_val = {8'b0, cfg_q};
      default:     reg_val = '0;
    endcase
  end

  assign isr_set = {tx_fin, rx_commit_i & ~srst_busy};
  assign isr_clr = (dwr && idx_q == IX_EVT) ? host_wdata_i[1:0] : 2'b00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      cfg_q      <= '0;
      len_q      <= '0;
      isr_q      <= '0;
      tx_req_q   <= 1'b0;
      srst_cnt   <= '0;
      rx_cp      <= '0;
      rvalid_q   <= 1'b0;
      from_mem_q <= 1'b0;
      rd_reg_q   <= '0;
    end else begin
      if (host_wr && !host_sel_i) idx_q <= host_wdata_i[7:0];

      if (srst_busy) begin
        srst_cnt <= srst_cnt - 1'b1;
        cfg_q    <= '0;
        len_q    <= '0;
        isr_q    <= '0;
        tx_req_q <= 1'b0;
      end else begin
        if (dwr && idx_q == IX_NET_CTRL && host_wdata_i[0]) srst_cnt <= CW'(RST_CYCLES);
        if (cfg_wr) cfg_q <= host_wdata_i[7:0];
        if (dwr && idx_q == IX_LEN_LO) len_q[7:0]  <= host_wdata_i[7:0];
        if (dwr && idx_q == IX_LEN_HI) len_q[15:8] <= host_wdata_i[7:0];
        isr_q <= (isr_q & ~isr_clr) | isr_set;
        if (tx_fin) tx_req_q <= 1'b0;
        else if (dwr && idx_q == IX_TX_CTRL && host_wdata_i[0]) tx_req_q <= 1'b1;
      end

      // committed pointer bounds what the host may read
      if (clr_all)          rx_cp <= rx_cbase;
      else if (rx_commit_i) rx_cp <= rx_wp;

      rvalid_q   <= host_rd;
      from_mem_q <= drd & is_rd_cmd & ~rx_empty;
      if (host_rd) begin
        if (!host_sel_i)    rd_reg_q <= {8'b0, idx_q};
        else if (is_rd_cmd) rd_reg_q <= '0;
        else                rd_reg_q <= reg_val;
      end
    end
  end

  assign host_rdata_o  = from_mem_q ? sram_q : rd_reg_q;
  assign host_rvalid_o = rvalid_q;
  assign tx_req_o      = tx_req_q;
  assign tx_len_o      = len_q;
endmodule

// File: rtl/pktbuf_host_port_chk.sv
module pktbuf_host_port_chk #(
  parameter int AW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          host_cs_i,
  input logic          host_we_i,
  input logic          host_rvalid_o,
  input logic          tx_req_o,
  input logic          tx_done_i,
  input logic          rx_commit_i,
  input logic          srst_busy,
  input logic [1:0]    isr_q,
  input logic [AW-1:0] tx_wp
);
  assert_rvalid_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_cs_i && !host_we_i) |=> host_rvalid_o);

  assert_rvalid_source_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rvalid_o |-> $past(host_cs_i && !host_we_i));

  assert_txreq_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && !tx_done_i && !srst_busy) |=> tx_req_o);

  assert_txreq_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && tx_done_i) |=> !tx_req_o);

  assert_txdone_event_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && tx_done_i && !srst_busy) |=> (isr_q[1] && tx_wp == '0));

  assert_commit_event_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_commit_i && !srst_busy) |=> isr_q[0]);

  assert_srst_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_busy |=> (isr_q == 2'b00 && !tx_req_o && tx_wp == '0));
endmodule

bind pktbuf_host_port pktbuf_host_port_chk #(.AW(AW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_cs_i(host_cs_i), .host_we_i(host_we_i),
  .host_rvalid_o(host_rvalid_o), .tx_req_o(tx_req_o), .tx_done_i(tx_done_i),
  .rx_commit_i(rx_commit_i), .srst_busy(srst_busy), .isr_q(isr_q), .tx_wp(tx_wp));

// File: tb/pktbuf_host_port_tb_top.sv
`timescale 1ns/1ps
module pktbuf_host_port_tb_top;
  localparam int BUF_WORDS = 2048;
  localparam int AW        = $clog2(BUF_WORDS);
  localparam int TX_WORDS  = BUF_WORDS * 3 / 16;
  localparam int RX_WORDS  = BUF_WORDS - TX_WORDS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_cs = 0, host_we = 0, host_sel = 0;
  logic [15:0] host_wdata = '0, host_rdata, tx_len, mac_rd_data;
  logic host_rvalid, tx_req, tx_done = 0, rx_wr = 0, rx_commit = 0;
  logic [AW-1:0] mac_rd_addr = '0;
  logic [15:0] rx_wdata = '0;

  int errors = 0, checks = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pktbuf_host_port #(.BUF_WORDS(BUF_WORDS), .RST_CYCLES(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .host_cs_i(host_cs), .host_we_i(host_we),
    .host_sel_i(host_sel), .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .host_rvalid_o(host_rvalid), .tx_req_o(tx_req), .tx_len_o(tx_len),
    .tx_done_i(tx_done), .mac_rd_addr_i(mac_rd_addr), .mac_rd_data_o(mac_rd_data),
    .rx_wr_i(rx_wr), .rx_wdata_i(rx_wdata), .rx_commit_i(rx_commit));

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) check(host_rdata, 16'hxxxx, "R1 unexpected read");
      else check(host_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic host_w(input logic sel, input logic [15:0] d);
    @(negedge clk);
    host_cs = 1; host_we = 1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_cs = 0; host_we = 0;
  endtask

  task automatic host_r(input logic sel, input logic [15:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    host_cs = 1; host_we = 0; host_sel = sel;
    @(negedge clk);
    host_cs = 0;
  endtask

  task automatic reg_w(input logic [7:0] ix, input logic [15:0] d);
    host_w(1'b0, {8'h00, ix}); host_w(1'b1, d);
  endtask

  task automatic reg_r(input logic [7:0] ix, input logic [15:0] exp, input string tag);
    host_w(1'b0, {8'h00, ix}); host_r(1'b1, exp, tag);
  endtask

  task automatic mac_chk(input int a, input logic [15:0] exp, input string tag);
    @(negedge clk); mac_rd_addr = AW'(a);
    @(negedge clk); check(mac_rd_data, exp, tag);
  endtask

  task automatic mac_w(input logic [15:0] d);
    @(negedge clk); rx_wr = 1; rx_wdata = d;
    @(negedge clk); rx_wr = 0;
  endtask

  task automatic commit();
    @(negedge clk); rx_commit = 1;
    @(negedge clk); rx_commit = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check({15'b0, tx_req}, 16'h0, "R12 tx_req");
    check(tx_len, 16'h0, "R12 tx_len");
    check({15'b0, host_rvalid}, 16'h0, "R12 rvalid");
    reg_r(8'h02, 16'h0000, "R12 txctrl");
    reg_r(8'hFE, 16'h0000, "R12 events");
    reg_r(8'h00, 16'h0000, "R12 netctrl");
    // R1 index readback
    host_w(1'b0, 16'h00FD);
    host_r(1'b0, 16'h00FD, "R1 index");
    // R4 split on
    reg_w(8'hFF, 16'h0080);
    reg_r(8'hFF, 16'h0080, "R4 cfg");
    // R2 transmit streaming
    reg_w(8'hF8, 16'hA1A1); host_w(1'b1, 16'hB2B2); host_w(1'b1, 16'hC3C3);
    mac_chk(0, 16'hA1A1, "R2 word0");
    mac_chk(1, 16'hB2B2, "R2 word1");
    mac_chk(2, 16'hC3C3, "R2 word2");
    // R5 length
    reg_w(8'hFC, 16'h003C); reg_w(8'hFD, 16'h0005);
    check(tx_len, 16'h053C, "R5 tx_len");
    reg_r(8'hFC, 16'h003C, "R5 lo readback");
    // R6 request / completion
    reg_w(8'h02, 16'h0001);
    check({15'b0, tx_req}, 16'h1, "R6 req high");
    reg_r(8'h02, 16'h0001, "R6 readback busy");
    @(negedge clk); tx_done = 1;
    @(negedge clk); tx_done = 0;
    check({15'b0, tx_req}, 16'h0, "R6 req cleared");
    reg_r(8'h02, 16'h0000, "R6 readback done");
    reg_r(8'hFE, 16'h0002, "R7 tx event");
    // R9 write one to clear
    reg_w(8'hFE, 16'h0000);
    reg_r(8'hFE, 16'h0002, "R9 zero keeps");
    reg_w(8'hFE, 16'h0002);
    reg_r(8'hFE, 16'h0000, "R9 clear");
    // R7 pointer back to base
    reg_w(8'hF8, 16'h1111);
    mac_chk(0, 16'h1111, "R7 tx ptr rebase");
    // R10 empty peek
    reg_r(8'hF0, 16'h0000, "R10 empty peek");
    // R8 hidden until commit
    mac_w(16'h2201); mac_w(16'h0008);
    for (int i = 0; i < 4; i++) mac_w(16'hD000 + 16'(i));
    reg_r(8'hF0, 16'h0000, "R8 uncommitted hidden");
    commit();
    reg_r(8'hFE, 16'h0001, "R8 rx event");
    // R3 peek then consume
    reg_r(8'hF0, 16'h2201, "R3 peek header");
    host_r(1'b1, 16'h2201, "R3 peek no advance");
    reg_r(8'hF2, 16'h2201, "R3 read header");
    host_r(1'b1, 16'h0008, "R3 read length");
    for (int i = 0; i < 4; i++) host_r(1'b1, 16'hD000 + 16'(i), "R3 read data");
    host_r(1'b1, 16'h0000, "R10 empty read");
    // R4 receive wrap: fill remainder of region
    for (int i = 0; i < RX_WORDS - 6; i++) mac_w(16'h5A00 ^ 16'(i));
    commit();
    for (int i = 0; i < RX_WORDS - 6; i++) host_r(1'b1, 16'h5A00 ^ 16'(i), "R10 R3 fill stream");
    host_r(1'b1, 16'h0000, "R10 drained");
    mac_w(16'hBEEF);
    commit();
    mac_chk(TX_WORDS, 16'hBEEF, "R4 rx wrap base");
    host_r(1'b1, 16'hBEEF, "R4 rx wrap read");
    // R4 transmit wrap
    reg_w(8'hF8, 16'h3001);
    for (int k = 2; k < TX_WORDS; k++) host_w(1'b1, 16'h3000 + 16'(k));
    host_w(1'b1, 16'h7777);
    mac_chk(0, 16'h7777, "R4 tx wrap base");
    mac_chk(TX_WORDS - 1, 16'h3000 + 16'(TX_WORDS - 1), "R4 tx region end");
    mac_chk(TX_WORDS, 16'hBEEF, "R4 rx region untouched");
    // R11 soft reset
    reg_w(8'h02, 16'h0001);
    mac_w(16'h0101); commit();
    reg_w(8'h00, 16'h0001);
    reg_r(8'h00, 16'h0001, "R11 busy");
    reg_w(8'hFC, 16'h00AA);
    repeat (12) @(negedge clk);
    reg_r(8'h00, 16'h0000, "R11 done");
    reg_r(8'hFF, 16'h0000, "R11 cfg cleared");
    reg_r(8'hFE, 16'h0000, "R11 events cleared");
    reg_r(8'hFC, 16'h0000, "R11 length cleared");
    check({15'b0, tx_req}, 16'h0, "R11 req cleared");
    reg_r(8'hF0, 16'h0000, "R11 rx empty");
    reg_w(8'hF8, 16'hABCD);
    mac_chk(0, 16'hABCD, "R11 tx ptr base");
    repeat (3) @(negedge clk);
    check(16'(exp_q.size()), 16'h0, "R1 all reads returned");
    finish_run();
  end
endmodule